// File: doc/BRIEF.md
# Interrupt Priority Responder with Daisy-Chain Participation

This block sits between eight already-masked interrupt request bits and a processor's interrupt pin. It picks the lowest-numbered active request as the winner, raises a single interrupt request while any enabled request is pending, and drops its chain output so that cards further down a priority daisy chain stay quiet. A card control register lets software disable the whole block, or only the path that passes priority on down the chain.

When the processor runs an acknowledge cycle, or software reads the vector port, the block returns one byte on its read data port. In restart mode that byte is a one-byte restart opcode that carries the winning channel number. In table mode it is an entry from a 32-byte vector table. The table holds four groups of eight entries, and a strap picks the group. The request view and the enable are frozen for as long as the read lasts. When the read ends, the block sends a one-cycle clear pulse, with the winning channel number, back to the request latches. A strap can turn this clear pulse off. A chop input forces the interrupt output low so that edge-sensitive processors see a fresh edge.

Top module: `irqv_top`

## Requirements
- R1: The winner is the lowest-numbered set bit of the enabled request vector. Channel 0 has the highest priority.
- R2: Requests are enabled only when `chain_in_i` is 1 and control bit 0 is 0. `irq_o` is 1 exactly when an enabled request is pending and `chop_i` is 0.
- R3: `chain_out_o` is 0 whenever any of these holds: control bit 0 is 1, control bit 1 is 1, `chain_in_i` is 0, or this block is requesting. Control bit 1 alone leaves `irq_o` working.
- R4: Once this block has requested, `chain_out_o` stays 0 until a one-cycle pulse on `chain_rel_i`, even after the requests have gone away.
- R5: While `ack_i` or `vec_rd_i` is 1, changes on `req_i` and `chain_in_i` have no effect on `irq_o` or `rd_data_o`. The view captured in the cycle before the read starts is used instead.
- R6: With `mode_vec_i`=0, a read returns 8'hC7 OR (winner index shifted left by 3), so channels 0 to 7 give C7, CF, D7, DF, E7, EF, F7 and FF.
- R7: With `mode_vec_i`=1, a read returns the table entry at address {`grp_sel_i`, winner index}, with the group select in address bits 4:3.
- R8: In the first cycle after a read ends, `clr_pulse_o` is 1 for exactly one cycle. `clr_idx_o` carries the winner captured at the start of the read. No pulse appears when `autoclr_dis_i` is 1.
- R9: `chop_i`=1 forces `irq_o` to 0, and `irq_o` comes back once `chop_i` returns to 0.
- R10: A read with no enabled request returns 8'hFF and gives no clear pulse.
- R11: Reset clears both control bits. After reset, with no requests and `chain_in_i`=1, `irq_o` is 0, `chain_out_o` is 1 and `clr_pulse_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Masked request bits, bit 0 is the highest priority |
| chain_in_i | input | 1 | Priority granted from the card above, active high |
| chain_out_o | output | 1 | Priority passed to cards below, active high |
| ctrl_wr_i | input | 1 | Write strobe for the card control register |
| ctrl_wdata_i | input | 2 | Control data: bit 0 disables the block, bit 1 cuts the chain output |
| chain_rel_i | input | 1 | Program pulse that releases the held chain output |
| ack_i | input | 1 | Interrupt acknowledge cycle active |
| vec_rd_i | input | 1 | Vector port read active |
| mode_vec_i | input | 1 | Strap: 0 selects restart opcode, 1 selects vector table |
| grp_sel_i | input | 2 | Strap: vector table group |
| autoclr_dis_i | input | 1 | Strap: 1 suppresses the clear pulse |
| chop_i | input | 1 | Forces the interrupt output inactive |
| tbl_we_i | input | 1 | Vector table write enable |
| tbl_addr_i | input | 5 | Vector table write address |
| tbl_data_i | input | 8 | Vector table write data |
| irq_o | output | 1 | Interrupt request, active high |
| rd_data_o | output | 8 | Byte returned during a read, 8'hFF otherwise |
| clr_pulse_o | output | 1 | One-cycle clear pulse to the request latches |
| clr_idx_o | output | 3 | Channel number for the clear pulse |

## Verification
The hardest case to reach is a request arriving in the middle of an acknowledge. The bench sets up a lower-priority winner, starts the read, and then raises higher-priority bits while the read is still running. It checks that the byte and the clear index still name the original channel. A second hard case is the sticky chain hold, which only shows up once the request that set it has gone away. The bench withdraws every request and checks that `chain_out_o` stays low until the release pulse. The scoreboard queues the expected byte and clear for each read. Its monitor then matches them against the first read cycle and the cycle after the read ends.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NCH       = 8;
  localparam int IDXW      = $clog2(NCH);
  localparam int GRPW      = 2;
  localparam int TBL_AW    = IDXW + GRPW;
  localparam int TBL_DEPTH = 1 << TBL_AW;
  localparam int DW        = 8;
  localparam logic [DW-1:0] NO_HIT_BYTE = 8'hFF;
  localparam logic [DW-1:0] RST_BASE    = 8'hC7;

  typedef struct packed {
    logic            hit;
    logic [IDXW-1:0] idx;
  } win_t;

  // restart opcode: channel number lands in bits 5:3
  function automatic logic [DW-1:0] fn_rst_opcode(input logic [IDXW-1:0] idx);
    logic [DW-1:0] wide;
    wide = '0;
    wide[IDXW-1:0] = idx;
    return RST_BASE | (wide << 3);
  endfunction

  function automatic logic [TBL_AW-1:0] fn_tbl_addr(input logic [GRPW-1:0] grp,
                                                     input logic [IDXW-1:0] idx);
    return {grp, idx};
  endfunction
endpackage

// File: rtl/irqv_prio.sv
module irqv_prio
  import irqv_pkg::*;
#(
  parameter int N  = NCH,
  parameter int IW = IDXW
) (
  input  logic [N-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  logic [N:0]   lower_any;
  logic [N-1:0] grant;

  assign lower_any[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_stage
      assign lower_any[g+1] = lower_any[g] | req_i[g];
      assign grant[g]       = req_i[g] & ~lower_any[g];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx_o = idx_o | IW'(i);
    end
  end

  assign hit_o = lower_any[N];
endmodule

// File: rtl/irqv_freeze.sv
module irqv_freeze
  import irqv_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_active_i,
  input  logic [N-1:0] req_live_i,
  input  logic         en_live_i,
  output logic [N-1:0] req_eff_o,
  output logic         en_eff_o,
  output logic         read_start_o,
  output logic         read_end_o
);
  logic [N-1:0] req_hold;
  logic         en_hold;
  logic         rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_hold <= '0;
      en_hold  <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      rd_q <= rd_active_i;
      if (!rd_active_i) begin
        req_hold <= req_live_i;
        en_hold  <= en_live_i;
      end
    end
  end

  assign req_eff_o    = rd_active_i ? req_hold : req_live_i;
  assign en_eff_o     = rd_active_i ? en_hold  : en_live_i;
  assign read_start_o = rd_active_i & ~rd_q;
  assign read_end_o   = ~rd_active_i & rd_q;

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active_i && rd_q) |-> ($stable(req_eff_o) && $stable(en_eff_o))) // R5
    else $error("frozen view moved during read");
endmodule

// File: rtl/irqv_chain.sv
module irqv_chain (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr_i,
  input  logic [1:0] ctrl_wdata_i,
  input  logic       chain_rel_i,
  input  logic       chain_in_i,
  input  logic       requesting_i,
  output logic       blk_dis_o,
  output logic       chain_out_o
);
  logic [1:0] ctrl_q;
  logic       hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 2'b00;
      hold_q <= 1'b0;
    end else begin
      if (ctrl_wr_i) ctrl_q <= ctrl_wdata_i;
      if (chain_rel_i) hold_q <= 1'b0;
      else if (requesting_i) hold_q <= 1'b1;
    end
  end

  assign blk_dis_o   = ctrl_q[0];
  assign chain_out_o = chain_in_i & ~ctrl_q[0] & ~ctrl_q[1] & ~hold_q & ~requesting_i;

  AST_CHAIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(requesting_i) && !$past(chain_rel_i)) |-> !chain_out_o) // R4
    else $error("chain output released without program write");
endmodule

// File: rtl/irqv_vtable.sv
module irqv_vtable
  import irqv_pkg::*;
#(
  parameter int AW = TBL_AW,
  parameter int W  = DW
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/irqv_top.sv
module irqv_top
  import irqv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req_i,
  input  logic              chain_in_i,
  output logic              chain_out_o,
  input  logic              ctrl_wr_i,
  input  logic [1:0]        ctrl_wdata_i,
  input  logic              chain_rel_i,
  input  logic              ack_i,
  input  logic              vec_rd_i,
  input  logic              mode_vec_i,
  input  logic [GRPW-1:0]   grp_sel_i,
  input  logic              autoclr_dis_i,
  input  logic              chop_i,
  input  logic              tbl_we_i,
  input  logic [TBL_AW-1:0] tbl_addr_i,
  input  logic [DW-1:0]     tbl_data_i,
  output logic              irq_o,
  output logic [DW-1:0]     rd_data_o,
  output logic              clr_pulse_o,
  output logic [IDXW-1:0]   clr_idx_o
);
  logic            rd_active;
  logic            blk_dis;
  logic            en_live;
  logic [NCH-1:0]  req_eff;
  logic            en_eff;
  logic            read_start;
  logic            read_end;
  logic            win_hit;
  logic [IDXW-1:0] win_idx;
  logic [DW-1:0]   tbl_byte;
  logic [DW-1:0]   resp_byte;
  win_t            win_q;

  assign rd_active = ack_i | vec_rd_i;
  assign en_live   = chain_in_i & ~blk_dis;

  irqv_freeze #(.N(NCH)) i_freeze (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_active_i  (rd_active),
    .req_live_i   (req_i),
    .en_live_i    (en_live),
    .req_eff_o    (req_eff),
    .en_eff_o     (en_eff),
    .read_start_o (read_start),
    .read_end_o   (read_end)
  );

  irqv_prio #(.N(NCH), .IW(IDXW)) i_prio (
    .req_i (req_eff & {NCH{en_eff}}),
    .hit_o (win_hit),
    .idx_o (win_idx)
  );

  irqv_chain i_chain (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .chain_rel_i  (chain_rel_i),
    .chain_in_i   (chain_in_i),
    .requesting_i (win_hit),
    .blk_dis_o    (blk_dis),
    .chain_out_o  (chain_out_o)
  );

  irqv_vtable #(.AW(TBL_AW), .W(DW)) i_vtable (
    .clk     (clk),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (fn_tbl_addr(grp_sel_i, win_idx)),
    .rdata_o (tbl_byte)
  );

  always_comb begin
    if (!win_hit)        resp_byte = NO_HIT_BYTE;
    else if (mode_vec_i) resp_byte = tbl_byte;
    else                 resp_byte = fn_rst_opcode(win_idx);
  end

  assign rd_data_o = rd_active ? resp_byte : NO_HIT_BYTE;
  assign irq_o     = win_hit & ~chop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q       <= '0;
      clr_pulse_o <= 1'b0;
      clr_idx_o   <= '0;
    end else begin
      if (read_start) win_q <= '{hit: win_hit, idx: win_idx};
      clr_pulse_o <= read_end & win_q.hit & ~autoclr_dis_i;
      if (read_end) clr_idx_o <= win_q.idx;
    end
  end

  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse_o |=> !clr_pulse_o) // R8
    else $error("clear pulse longer than one cycle");

  AST_CLR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse_o |-> (!$past(rd_active) && $past(rd_active, 2))) // R8
    else $error("clear pulse not tied to end of read");

  AST_CHOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chop_i |-> !irq_o) // R9
    else $error("interrupt raised while chopped");
endmodule

// File: tb/test_irqv_top.sv
module test_irqv_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] req_i = '0;
  logic chain_in_i = 1'b1;
  logic chain_out_o;
  logic ctrl_wr_i = 1'b0;
  logic [1:0] ctrl_wdata_i = '0;
  logic chain_rel_i = 1'b0;
  logic ack_i = 1'b0;
  logic vec_rd_i = 1'b0;
  logic mode_vec_i = 1'b0;
  logic [1:0] grp_sel_i = '0;
  logic autoclr_dis_i = 1'b0;
  logic chop_i = 1'b0;
  logic tbl_we_i = 1'b0;
  logic [4:0] tbl_addr_i = '0;
  logic [7:0] tbl_data_i = '0;
  logic irq_o;
  logic [7:0] rd_data_o;
  logic clr_pulse_o;
  logic [2:0] clr_idx_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] byte_v;
    logic       clr;
    logic [2:0] idx;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irqv_top i_irqv_top (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .chain_in_i(chain_in_i),
    .chain_out_o(chain_out_o), .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
    .chain_rel_i(chain_rel_i), .ack_i(ack_i), .vec_rd_i(vec_rd_i),
    .mode_vec_i(mode_vec_i), .grp_sel_i(grp_sel_i), .autoclr_dis_i(autoclr_dis_i),
    .chop_i(chop_i), .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i),
    .tbl_data_i(tbl_data_i), .irq_o(irq_o), .rd_data_o(rd_data_o),
    .clr_pulse_o(clr_pulse_o), .clr_idx_o(clr_idx_o)
  );

  function automatic logic [7:0] tbl_val(input int a);
    return 8'(8'h10 + a * 5);
  endfunction

  function automatic logic [7:0] rst_byte(input int idx);
    return 8'(8'hC7 + idx * 8);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  task automatic set_req(input logic [7:0] v);
    drive_edge();
    req_i = v;
  endtask

  task automatic wr_ctrl(input logic [1:0] v);
    drive_edge();
    ctrl_wr_i = 1'b1;
    ctrl_wdata_i = v;
    drive_edge();
    ctrl_wr_i = 1'b0;
  endtask

  task automatic chain_release();
    drive_edge();
    chain_rel_i = 1'b1;
    drive_edge();
    chain_rel_i = 1'b0;
  endtask

  task automatic read_cycle(input bit use_vec, input int len, input logic [7:0] b,
                            input logic clr, input logic [2:0] idx, input string tag);
    exp_t e;
    e.byte_v = b; e.clr = clr; e.idx = idx; e.tag = tag;
    exp_q.push_back(e);
    drive_edge();
    if (use_vec) vec_rd_i = 1'b1; else ack_i = 1'b1;
    repeat (len) drive_edge();
    ack_i = 1'b0;
    vec_rd_i = 1'b0;
    repeat (3) drive_edge();
  endtask

  // monitor: byte in first read cycle, clear in the cycle after the read ends
  bit   prev_rd = 0;
  bit   chk_clr = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (rst_n) begin
      bit rd;
      rd = ack_i | vec_rd_i;
      if (chk_clr) begin
        chk_clr = 0;
        chk({cur.tag, " clear pulse"}, int'(clr_pulse_o), int'(cur.clr));
        if (cur.clr) chk({cur.tag, " clear index"}, int'(clr_idx_o), int'(cur.idx));
      end else if (clr_pulse_o) begin
        chk("R8 unexpected clear pulse", 1, 0);
      end
      if (rd && !prev_rd) begin
        if (exp_q.size() == 0) begin
          chk("scoreboard empty at read", 1, 0);
        end else begin
          cur = exp_q.pop_front();
          chk({cur.tag, " read byte"}, int'(rd_data_o), int'(cur.byte_v));
        end
      end
      if (!rd && prev_rd) chk_clr = 1;
      prev_rd = rd;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) drive_edge();
    for (int a = 0; a < 32; a++) begin
      drive_edge();
      tbl_we_i = 1'b1; tbl_addr_i = 5'(a); tbl_data_i = tbl_val(a);
    end
    drive_edge();
    tbl_we_i = 1'b0;
    rst_n = 1'b1;
    sample();
    chk("R11 reset irq", int'(irq_o), 0);
    chk("R11 reset chain_out", int'(chain_out_o), 1);
    chk("R11 reset clear", int'(clr_pulse_o), 0);

    // R1 / R6 / R8 restart mode
    set_req(8'b0010_0100);
    sample();
    chk("R2 irq with request", int'(irq_o), 1);
    chk("R3 chain_out while requesting", int'(chain_out_o), 0);
    read_cycle(0, 2, rst_byte(2), 1'b1, 3'd2, "R1 R6 R8 ch2");
    set_req(8'b0010_0000);
    read_cycle(1, 1, rst_byte(5), 1'b1, 3'd5, "R6 R8 ch5");
    set_req(8'b1000_0001);
    read_cycle(0, 1, rst_byte(0), 1'b1, 3'd0, "R1 ch0 over ch7");

    // R4 sticky chain hold
    set_req(8'h00);
    repeat (2) drive_edge();
    sample();
    chk("R4 chain held after requests gone", int'(chain_out_o), 0);
    chain_release();
    sample();
    chk("R4 chain released by write", int'(chain_out_o), 1);

    // R3 control bit 1 cuts chain only
    wr_ctrl(2'b10);
    sample();
    chk("R3 ctrl bit1 chain_out", int'(chain_out_o), 0);
    set_req(8'h01);
    sample();
    chk("R3 ctrl bit1 irq still works", int'(irq_o), 1);
    set_req(8'h00);
    chain_release();
    sample();
    chk("R3 ctrl bit1 holds chain low", int'(chain_out_o), 0);

    // R2 control bit 0 disables block
    wr_ctrl(2'b01);
    set_req(8'h80);
    sample();
    chk("R2 ctrl bit0 irq", int'(irq_o), 0);
    chk("R3 ctrl bit0 chain_out", int'(chain_out_o), 0);
    read_cycle(0, 1, 8'hFF, 1'b0, 3'd0, "R10 disabled read");
    wr_ctrl(2'b00);
    sample();
    chk("R2 re-enabled irq", int'(irq_o), 1);
    read_cycle(0, 1, rst_byte(7), 1'b1, 3'd7, "R6 ch7");
    set_req(8'h00);
    chain_release();
    sample();
    chk("R3 chain passes after clear", int'(chain_out_o), 1);

    // R2 chain_in low
    drive_edge();
    chain_in_i = 1'b0;
    req_i = 8'h10;
    sample();
    chk("R2 chain_in low irq", int'(irq_o), 0);
    chk("R3 chain_in low chain_out", int'(chain_out_o), 0);
    drive_edge();
    chain_in_i = 1'b1;
    req_i = 8'h00;

    // R7 vector mode
    drive_edge();
    mode_vec_i = 1'b1;
    grp_sel_i = 2'd2;
    req_i = 8'h08;
    read_cycle(1, 1, tbl_val(19), 1'b1, 3'd3, "R7 grp2 ch3");
    drive_edge();
    grp_sel_i = 2'd0;
    req_i = 8'h80;
    read_cycle(0, 2, tbl_val(7), 1'b1, 3'd7, "R7 grp0 ch7");
    drive_edge();
    grp_sel_i = 2'd3;
    req_i = 8'h41;
    read_cycle(0, 1, tbl_val(24), 1'b1, 3'd0, "R7 grp3 ch0");

    // R8 strap off
    drive_edge();
    autoclr_dis_i = 1'b1;
    read_cycle(0, 1, tbl_val(24), 1'b0, 3'd0, "R8 autoclear disabled");
    drive_edge();
    autoclr_dis_i = 1'b0;
    mode_vec_i = 1'b0;

    // R9 chop
    drive_edge();
    chop_i = 1'b1;
    sample();
    chk("R9 chop forces irq low", int'(irq_o), 0);
    drive_edge();
    chop_i = 1'b0;
    sample();
    chk("R9 irq back after chop", int'(irq_o), 1);

    // R10 no request
    set_req(8'h00);
    read_cycle(1, 1, 8'hFF, 1'b0, 3'd0, "R10 idle read");

    // R5 freeze during read
    set_req(8'b0001_0000);
    begin
      exp_t e;
      e.byte_v = rst_byte(4); e.clr = 1'b1; e.idx = 3'd4; e.tag = "R5 frozen ch4";
      exp_q.push_back(e);
    end
    drive_edge();
    ack_i = 1'b1;
    drive_edge();
    req_i = 8'b0000_0011;
    chain_in_i = 1'b0;
    sample();
    chk("R5 byte held during read", int'(rd_data_o), int'(rst_byte(4)));
    chk("R5 irq held during read", int'(irq_o), 1);
    drive_edge();
    ack_i = 1'b0;
    repeat (3) drive_edge();
    chain_in_i = 1'b1;
    sample();
    chk("R1 live view after read", int'(irq_o), 1);
    read_cycle(0, 1, rst_byte(0), 1'b1, 3'd0, "R1 ch0 after freeze");

    set_req(8'h00);
    repeat (3) drive_edge();
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule